// File: doc/BRIEF.md
# Sequential 16-bit Multiply/Divide Unit

This unit carries out the four word-sized multiply and divide operations of a CPU with 32-bit data registers. The four operations are unsigned multiply, signed multiply, unsigned divide and signed divide. A request carries four things: the current value of the destination register, a 16-bit source operand, a multiply-or-divide select and a signed select.

- **Multiply** uses the low half of the destination value as its second factor. It returns the full 32-bit product.
- **Divide** splits the whole 32-bit destination value by the source. It returns the remainder in the upper half and the quotient in the lower half. When the quotient does not fit, it returns no result.
- **Zero divisor** produces a trap request and no result.

Each completion also reports:
- the N, Z, V and C condition flags,
- a write-enable for the destination register,
- the nominal instruction cycle count, which the surrounding core charges for the instruction.

The input side is a valid/ready stream with a depth of one operation. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the unit is idle. A request held while `req_ready` is low does not transfer and has no effect. The output side has no back-pressure. `done` pulses for one cycle, and all result outputs stay constant from that pulse until the next completion. The divider is bit-serial, so the latency varies with the operands. The multiplier always takes one step per source bit.

Top module: `muldiv16_unit`

## Requirements
- R1: Unsigned multiply zero-extends `req_dst[15:0]` and `req_src` and returns their 32-bit product with `res_wr_en`=1. N is bit 31 of the product, Z is set when the product is zero, and V and C are 0.
- R2: Signed multiply sign-extends `req_dst[15:0]` and `req_src` and returns their 32-bit two's-complement product. The flags follow the same rules as R1 and `res_wr_en` is 1.
- R3: Unsigned divide treats `req_src` as a zero-extended 16-bit divisor and `req_dst` as a 32-bit dividend. When the quotient fits in 16 bits, `res_data` = {remainder[15:0], quotient[15:0]} and `res_wr_en`=1. N is quotient bit 15, Z is set when the 16-bit quotient is zero, and V=C=0.
- R4: Signed divide truncates toward zero. The quotient is negative exactly when one operand is negative, and the remainder has the sign of the dividend. Result packing and flags follow R3.
- R5: An unsigned quotient above 0xFFFF gives V=1, N=Z=C=0, `res_wr_en`=0, and `res_data` equal to the unchanged `req_dst`.
- R6: A signed quotient outside -32768..32767 gives the same outputs as R5. This includes 0x80000000 divided by 0xFFFF.
- R7: A zero divisor (either signedness) gives `trap_req`=1 and `trap_vec`=0x14, with `res_wr_en`=0, N=Z=V=C=0 and `res_data` = `req_dst`. `trap_req` is 0 and `trap_vec` is 0 for every other outcome.
- R8: `cycles` reports 54 for a multiply, 140 for an unsigned divide and 158 for a signed divide. Each divide value is increased by 38 on a zero divisor.
- R9: `req_ready` is high when idle and low from the cycle after a transfer until `done`. `done` is high for exactly one cycle per transferred request.
- R10: A request presented while `req_ready` is low is not taken. It does not change the result of the operation in flight.
- R11: `res_data`, `res_wr_en`, the flags, `trap_req`, `trap_vec` and `cycles` change only in the cycle `done` is high.
- R12: After reset `req_ready`=1 and `done`=0, and every result output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle; request transfers when both are high |
| req_is_div | input | 1 | 1 = divide, 0 = multiply |
| req_signed | input | 1 | 1 = signed form |
| req_dst | input | 32 | Destination register value |
| req_src | input | 16 | Source operand |
| done | output | 1 | One-cycle completion pulse |
| res_data | output | 32 | Value for the destination register |
| res_wr_en | output | 1 | Destination register must be written |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag (always 0) |
| trap_req | output | 1 | Divide-by-zero trap request |
| trap_vec | output | 8 | Trap vector offset |
| cycles | output | 8 | Nominal instruction cycle count |

## Verification
The hardest case to reach from the ports is a competing request that arrives while an operation is in flight. The stimulus starts a 16-step multiply and keeps `req_valid` high with a different divide request for several cycles while `req_ready` is low. It then drops the request and checks that the completed result belongs to the first request. The signed overflow edges also need care, because only a few dividends hit them. The vectors place quotients at exactly +32767, +32768 and -32768, and include the most-negative dividend divided by -1.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  localparam int unsigned CYC_MUL      = 54;
  localparam int unsigned CYC_DIV_U    = 140;
  localparam int unsigned CYC_DIV_S    = 158;
  localparam int unsigned CYC_DIV_ZERO = 38;
  localparam logic [7:0]  VEC_DIV_ZERO = 8'h14;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MUL,
    ST_DIV,
    ST_TRAP
  } ctl_state_e;

  typedef enum logic [1:0] {
    DV_IDLE,
    DV_ALIGN,
    DV_STEP
  } div_phase_e;
endpackage

// File: rtl/muldiv_mul_core.sv
module muldiv_mul_core #(
  parameter int unsigned OP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              signed_i,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic              done_o,
  output logic [2*OP_W-1:0] prod_o
);
  localparam int unsigned RW = 2 * OP_W;
  localparam int unsigned CW = $clog2(OP_W);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [RW-1:0] acc, mcand, corr;
  logic [OP_W-1:0] mplier;
  logic [RW-1:0] sum_w;

  assign sum_w  = acc + (mplier[0] ? mcand : '0);
  assign prod_o = acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      acc    <= '0;
      mcand  <= '0;
      corr   <= '0;
      mplier <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy) begin
        busy   <= 1'b1;
        cnt    <= '0;
        acc    <= '0;
        mcand  <= signed_i ? {{OP_W{a_i[OP_W-1]}}, a_i} : {{OP_W{1'b0}}, a_i};
        mplier <= b_i;
        corr   <= (signed_i && b_i[OP_W-1]) ? {a_i, {OP_W{1'b0}}} : '0;
      end else if (busy) begin
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt + 1'b1;
        if (cnt == CW'(OP_W - 1)) begin
          busy   <= 1'b0;
          done_o <= 1'b1;
          acc    <= sum_w - corr;
        end else begin
          acc <= sum_w;
        end
      end
    end
  end

  // R9
  mul_done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R9
  mul_busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy) |=> (busy && !done_o));
endmodule

// File: rtl/muldiv_div_core.sv
module muldiv_div_core
  import muldiv_pkg::*;
#(
  parameter int unsigned OP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2*OP_W-1:0] num_i,
  input  logic [OP_W-1:0]   den_i,
  output logic              done_o,
  output logic [2*OP_W-1:0] quo_o,
  output logic [OP_W-1:0]   rem_o
);
  localparam int unsigned RW = 2 * OP_W;

  div_phase_e    phase;
  logic [RW-1:0] part, shd, den, quo;
  logic          ge;

  assign ge    = part >= shd;
  assign quo_o = quo;
  assign rem_o = part[OP_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= DV_IDLE;
      part   <= '0;
      shd    <= '0;
      den    <= '0;
      quo    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (phase)
        DV_IDLE: if (start_i) begin
          part  <= num_i;
          den   <= {{OP_W{1'b0}}, den_i};
          shd   <= {{OP_W{1'b0}}, den_i};
          quo   <= '0;
          phase <= DV_ALIGN;
        end
        DV_ALIGN: begin
          if (shd <= (part >> 1)) shd <= shd << 1;
          else                    phase <= DV_STEP;
        end
        DV_STEP: begin
          quo <= {quo[RW-2:0], ge};
          if (ge) part <= part - shd;
          if (shd == den) begin
            phase  <= DV_IDLE;
            done_o <= 1'b1;
          end else begin
            shd <= shd >> 1;
          end
        end
        default: phase <= DV_IDLE;
      endcase
    end
  end

  // R3
  rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ({{OP_W{1'b0}}, rem_o} < den));
  // R3
  shift_not_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == DV_STEP) |-> (shd >= den));
endmodule

// File: rtl/muldiv16_unit.sv
module muldiv16_unit
  import muldiv_pkg::*;
#(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned CYC_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_is_div,
  input  logic                req_signed,
  input  logic [2*OP_W-1:0]   req_dst,
  input  logic [OP_W-1:0]     req_src,
  output logic                done,
  output logic [2*OP_W-1:0]   res_data,
  output logic                res_wr_en,
  output logic                flag_n,
  output logic                flag_z,
  output logic                flag_v,
  output logic                flag_c,
  output logic                trap_req,
  output logic [7:0]          trap_vec,
  output logic [CYC_W-1:0]    cycles
);
  localparam int unsigned RW = 2 * OP_W;
  localparam logic [RW-1:0] Q_POS_MAX = (RW'(1) << (OP_W - 1)) - RW'(1);
  localparam logic [RW-1:0] Q_NEG_MAX = RW'(1) << (OP_W - 1);

  ctl_state_e state;
  logic accept, num_neg, den_neg, den_zero;
  logic [RW-1:0]   num_mag;
  logic [OP_W-1:0] den_mag;
  logic mul_done, div_done;
  logic [RW-1:0]   mul_prod, div_quo;
  logic [OP_W-1:0] div_rem;

  logic [RW-1:0] dst_q;
  logic op_sgn_q, neg_num_q, neg_quo_q;

  logic [OP_W-1:0] q_fix, r_fix;
  logic div_ovf;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign num_neg   = req_signed && req_dst[RW-1];
  assign den_neg   = req_signed && req_src[OP_W-1];
  assign num_mag   = num_neg ? (~req_dst + 1'b1) : req_dst;
  assign den_mag   = den_neg ? (~req_src + 1'b1) : req_src;
  assign den_zero  = (req_src == '0);

  muldiv_mul_core #(.OP_W(OP_W)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (accept && !req_is_div),
    .signed_i (req_signed),
    .a_i      (req_dst[OP_W-1:0]),
    .b_i      (req_src),
    .done_o   (mul_done),
    .prod_o   (mul_prod)
  );

  muldiv_div_core #(.OP_W(OP_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (accept && req_is_div && !den_zero),
    .num_i   (num_mag),
    .den_i   (den_mag),
    .done_o  (div_done),
    .quo_o   (div_quo),
    .rem_o   (div_rem)
  );

  assign q_fix = neg_quo_q ? (~div_quo[OP_W-1:0] + 1'b1) : div_quo[OP_W-1:0];
  assign r_fix = neg_num_q ? (~div_rem + 1'b1) : div_rem;

  always_comb begin
    if (op_sgn_q) div_ovf = neg_quo_q ? (div_quo > Q_NEG_MAX) : (div_quo > Q_POS_MAX);
    else          div_ovf = |div_quo[RW-1:OP_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      dst_q     <= '0;
      op_sgn_q  <= 1'b0;
      neg_num_q <= 1'b0;
      neg_quo_q <= 1'b0;
      done      <= 1'b0;
      res_data  <= '0;
      res_wr_en <= 1'b0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_v    <= 1'b0;
      flag_c    <= 1'b0;
      trap_req  <= 1'b0;
      trap_vec  <= '0;
      cycles    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          dst_q     <= req_dst;
          op_sgn_q  <= req_signed;
          neg_num_q <= num_neg;
          neg_quo_q <= num_neg ^ den_neg;
          if (!req_is_div)   state <= ST_MUL;
          else if (den_zero) state <= ST_TRAP;
          else               state <= ST_DIV;
        end
        ST_MUL: if (mul_done) begin
          res_data  <= mul_prod;
          res_wr_en <= 1'b1;
          flag_n    <= mul_prod[RW-1];
          flag_z    <= (mul_prod == '0);
          flag_v    <= 1'b0;
          flag_c    <= 1'b0;
          trap_req  <= 1'b0;
          trap_vec  <= '0;
          cycles    <= CYC_W'(CYC_MUL);
          done      <= 1'b1;
          state     <= ST_IDLE;
        end
        ST_DIV: if (div_done) begin
          trap_req <= 1'b0;
          trap_vec <= '0;
          flag_c   <= 1'b0;
          cycles   <= op_sgn_q ? CYC_W'(CYC_DIV_S) : CYC_W'(CYC_DIV_U);
          if (div_ovf) begin
            res_data  <= dst_q;
            res_wr_en <= 1'b0;
            flag_n    <= 1'b0;
            flag_z    <= 1'b0;
            flag_v    <= 1'b1;
          end else begin
            res_data  <= {r_fix, q_fix};
            res_wr_en <= 1'b1;
            flag_n    <= q_fix[OP_W-1];
            flag_z    <= (q_fix == '0);
            flag_v    <= 1'b0;
          end
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        ST_TRAP: begin
          res_data  <= dst_q;
          res_wr_en <= 1'b0;
          flag_n    <= 1'b0;
          flag_z    <= 1'b0;
          flag_v    <= 1'b0;
          flag_c    <= 1'b0;
          trap_req  <= 1'b1;
          trap_vec  <= VEC_DIV_ZERO;
          cycles    <= CYC_W'((op_sgn_q ? CYC_DIV_S : CYC_DIV_U) + CYC_DIV_ZERO);
          done      <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R11
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_data) && $stable(res_wr_en) && $stable(cycles) && $stable(trap_req)));
  // R7
  trap_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_vec == 8'h14 && !res_wr_en && !flag_v));
  // R5
  no_write_on_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_v |-> (!res_wr_en && !flag_c && !trap_req));
  // R1
  carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !flag_c);
endmodule

// File: tb/test_muldiv16_unit.sv
`timescale 1ns/1ps
module test_muldiv16_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_is_div = 1'b0;
  logic req_signed = 1'b0;
  logic [31:0] req_dst = '0;
  logic [15:0] req_src = '0;
  logic done;
  logic [31:0] res_data;
  logic res_wr_en, flag_n, flag_z, flag_v, flag_c, trap_req;
  logic [7:0] trap_vec, cycles;

  int errors = 0;
  int checks = 0;
  int cyc_cnt = 0;

  always #2 clk = ~clk;

  muldiv16_unit i_muldiv16_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_div(req_is_div), .req_signed(req_signed), .req_dst(req_dst),
    .req_src(req_src), .done(done), .res_data(res_data), .res_wr_en(res_wr_en),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .trap_req(trap_req), .trap_vec(trap_vec), .cycles(cycles)
  );

  typedef struct packed {
    logic        is_div;
    logic        sgn;
    logic [31:0] dst;
    logic [15:0] src;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 32'h0000_1234, 16'h5678},
    '{1'b0, 1'b0, 32'hABCD_FFFF, 16'hFFFF},
    '{1'b0, 1'b0, 32'h0000_0000, 16'h9ABC},
    '{1'b0, 1'b1, 32'h0000_FFFF, 16'h0002},
    '{1'b0, 1'b1, 32'h0000_8000, 16'h8000},
    '{1'b0, 1'b1, 32'h0000_8000, 16'h7FFF},
    '{1'b1, 1'b0, 32'h0000_0064, 16'h0007},
    '{1'b1, 1'b0, 32'h0001_0000, 16'h0001},
    '{1'b1, 1'b0, 32'h0000_FFFF, 16'h0001},
    '{1'b1, 1'b0, 32'h0000_0005, 16'h000A},
    '{1'b1, 1'b0, 32'h1234_5678, 16'hABCD},
    '{1'b1, 1'b0, 32'hFFFF_FFFF, 16'hFFFF},
    '{1'b1, 1'b1, 32'hFFFF_FF9C, 16'h0007},
    '{1'b1, 1'b1, 32'h0000_0064, 16'hFFF9},
    '{1'b1, 1'b1, 32'hFFFF_FF9C, 16'hFFF9},
    '{1'b1, 1'b1, 32'h0001_0000, 16'h0001},
    '{1'b1, 1'b1, 32'hFFFF_8000, 16'h0001},
    '{1'b1, 1'b1, 32'h0000_7FFF, 16'h0001},
    '{1'b1, 1'b1, 32'h0000_8000, 16'h0001},
    '{1'b1, 1'b1, 32'h8000_0000, 16'hFFFF},
    '{1'b1, 1'b0, 32'h0000_1234, 16'h0000},
    '{1'b1, 1'b1, 32'hFFFF_0000, 16'h0000}
  };

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model(input vec_t v, output logic [31:0] res, output logic wr,
                                output logic [3:0] nzvc, output logic trap, output logic [7:0] cyc,
                                output string tag);
    longint n, d, q, r, p;
    logic ovf;
    trap = 1'b0;
    if (!v.is_div) begin
      if (v.sgn) p = longint'($signed(v.dst[15:0])) * longint'($signed(v.src));
      else       p = longint'({48'd0, v.dst[15:0]}) * longint'({48'd0, v.src});
      res = p[31:0]; wr = 1'b1; cyc = 8'd54;
      nzvc = {res[31], res == 32'd0, 2'b00};
      tag = v.sgn ? "R2" : "R1";
    end else begin
      cyc = v.sgn ? 8'd158 : 8'd140;
      if (v.src == 16'd0) begin
        trap = 1'b1; wr = 1'b0; nzvc = 4'b0000; res = v.dst; cyc = cyc + 8'd38;
        tag = "R7";
      end else begin
        if (v.sgn) begin n = longint'($signed(v.dst)); d = longint'($signed(v.src)); end
        else       begin n = longint'({32'd0, v.dst}); d = longint'({48'd0, v.src}); end
        q = n / d;
        r = n % d;
        ovf = v.sgn ? (q > 32767 || q < -32768) : (q > 65535);
        if (ovf) begin
          res = v.dst; wr = 1'b0; nzvc = 4'b0010;
          tag = v.sgn ? "R6" : "R5";
        end else begin
          res = {r[15:0], q[15:0]}; wr = 1'b1;
          nzvc = {q[15], q[15:0] == 16'd0, 2'b00};
          tag = v.sgn ? "R4" : "R3";
        end
      end
    end
  endfunction

  task automatic wait_done(output bit seen);
    int n = 0;
    seen = 1'b0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    seen = done;
  endtask

  task automatic drive(input vec_t v);
    req_is_div = v.is_div; req_signed = v.sgn; req_dst = v.dst; req_src = v.src;
  endtask

  task automatic check_outputs(input vec_t v);
    logic [31:0] eres; logic ewr, etrap; logic [3:0] enz; logic [7:0] ecyc; string tag;
    model(v, eres, ewr, enz, etrap, ecyc, tag);
    check(res_data == eres, {tag, " result"}, 64'(res_data), 64'(eres));
    check(res_wr_en == ewr, {tag, " write enable"}, 64'(res_wr_en), 64'(ewr));
    check({flag_n, flag_z, flag_v, flag_c} == enz, {tag, " flags"},
          64'({flag_n, flag_z, flag_v, flag_c}), 64'(enz));
    check(trap_req == etrap && trap_vec == (etrap ? 8'h14 : 8'h00), "R7 trap outputs",
          64'({trap_req, trap_vec}), 64'({etrap, (etrap ? 8'h14 : 8'h00)}));
    check(cycles == ecyc, "R8 cycle count", 64'(cycles), 64'(ecyc));
  endtask

  task automatic run_op(input vec_t v);
    bit seen;
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready when idle", 64'(req_ready), 64'd1);
    drive(v);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R9 ready low after transfer", 64'(req_ready), 64'd0);
    wait_done(seen);
    check(seen, "R9 done arrives", 64'(seen), 64'd1);
    check_outputs(v);
    @(negedge clk);
    check(done == 1'b0, "R9 done single cycle", 64'(done), 64'd0);
  endtask

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc_cnt);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    vec_t va, vb;
    logic [31:0] hold_res; logic [7:0] hold_cyc; logic [3:0] hold_f; logic hold_wr;
    bit seen;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(req_ready == 1'b1 && done == 1'b0, "R12 handshake reset", 64'({req_ready, done}), 64'b10);
    check(res_data == '0 && res_wr_en == 1'b0 && cycles == '0, "R12 result reset",
          64'(res_data), 64'd0);
    check({flag_n, flag_z, flag_v, flag_c, trap_req} == '0 && trap_vec == '0, "R12 flags reset",
          64'({flag_n, flag_z, flag_v, flag_c, trap_req, trap_vec}), 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_op(VECS[i]);

    // R10 request held while busy is not taken
    va = '{1'b0, 1'b1, 32'h0000_FFF0, 16'h0123};
    vb = '{1'b1, 1'b0, 32'h0000_0100, 16'h0000};
    @(negedge clk);
    drive(va); req_valid = 1'b1;
    @(negedge clk);
    drive(vb);
    for (int k = 0; k < 4; k++) begin
      check(req_ready == 1'b0, "R10 ready low while busy", 64'(req_ready), 64'd0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    wait_done(seen);
    check(seen, "R10 done for first request", 64'(seen), 64'd1);
    check_outputs(va);
    check(trap_req == 1'b0, "R10 competing trap request ignored", 64'(trap_req), 64'd0);

    // R11 outputs held after completion
    hold_res = res_data; hold_cyc = cycles; hold_wr = res_wr_en;
    hold_f = {flag_n, flag_z, flag_v, flag_c};
    repeat (6) @(negedge clk);
    check(res_data == hold_res && cycles == hold_cyc && res_wr_en == hold_wr &&
          {flag_n, flag_z, flag_v, flag_c} == hold_f, "R11 outputs hold",
          64'(res_data), 64'(hold_res));

    // R5 overflow after a successful result: destination unchanged
    run_op('{1'b1, 1'b0, 32'h00FF_0000, 16'h00FF});
    // R8 signed zero divide count after unsigned divide
    run_op('{1'b1, 1'b1, 32'h0000_0001, 16'h0000});
    // R2 most-negative times most-negative repeated after trap
    run_op('{1'b0, 1'b1, 32'hFFFF_8000, 16'h8000});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule